// File: doc/BRIEF.md
# Printer Port Register Interface

This block is the host-side register file of a byte-wide printer port. A synchronous bus reaches three registers through a 3-bit offset: a data latch at offset 0, a status register at offset 1 and a control register at offset 2. Every other offset reads as 0xFF and ignores writes. The block drives a one-cycle byte-out pulse toward a printer-side sink and a level interrupt request. A data read returns either the byte last written or a sampled input byte, depending on the direction bit in control.

No external printer is involved in the handshake. The block models it with a small state machine over the busy and acknowledge status bits. The state machine has three states:

- HS_READY: busy bit 1 (not busy), acknowledge 1.
- HS_STROBED: busy bit 0, acknowledge 1.
- HS_ACK_LOW: busy bit 0, acknowledge 0.

It has four transitions:

- T_REINIT: any state to HS_READY, on a control write with the initialize bit at 0.
- T_STROBE: HS_READY to HS_STROBED, on a control write with initialize, select and strobe all at 1. HS_STROBED and HS_ACK_LOW stay where they are on this event.
- T_ACK_DROP: HS_STROBED to HS_ACK_LOW, on a status read while the stored strobe bit is 0.
- T_ACK_RISE: HS_ACK_LOW to HS_READY, on a status read while the stored strobe bit is 0.

A status read while in HS_READY leaves the state unchanged.

Accesses are single-cycle strobes, and reads return their value one cycle later on a separate read-data port.

Top module: `lpt_regs`

## Requirements
- R1: After reset, a data read returns 0xFF, a status read returns 0xD9, a control read returns 0xCC, and irq is 0.
- R2: Offsets 3 to 7 read as 0xFF. Writes to offsets 1 and 3 to 7 change no register.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1. The control fields are: bit 5 direction (1 = input), bit 4 interrupt enable, bit 3 select, bit 2 initialize (active low), bit 1 auto-linefeed, bit 0 strobe.
- R4: A control write with bit 2 at 0 sets status to 0xD8. The status fields are: bit 7 not-busy, bit 6 acknowledge, bit 5 paper-out (always 0), bit 4 online (always 1), bit 3 no-error (always 1), bit 0 timeout. Because bit 0 of 0xD8 is 0, this write also clears the timeout flag, and the timeout flag is 1 after reset. This write never raises irq.
- R5: A control write with bits 2, 3 and 0 all at 1 clears status bit 7. If the stored strobe bit was 0 before this write, out_valid pulses for exactly one cycle, starting the cycle after the write, with out_byte equal to the data latch.
- R6: A control write with bits 2 and 3 at 1 and bit 0 at 0 sets irq from the next cycle, but only if the interrupt-enable bit stored before the write is 1. An enable set by the same write does not count.
- R7: A status read returns the status value from before the read and drops irq on the next cycle.
- R8: A status read while status bit 7 is 0 and the stored strobe bit is 0 steps the handshake: an acknowledge of 1 is cleared; an acknowledge of 0 sets both bit 6 and bit 7. Otherwise the read leaves status unchanged.
- R9: A data read returns the sampled input byte prn_din (sampled every clock) when control bit 5 is 1. Otherwise it returns the last byte written to offset 0.
- R10: Read data appears on bus_rdata in the cycle after bus_rd and holds between reads. If bus_rd and bus_wr are high together, the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (3) | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Registered read data |
| prn_din | input | DW (8) | Printer-side input byte |
| irq | output | 1 | Level interrupt request (pending flag) |
| out_valid | output | 1 | One-cycle pulse: a byte is emitted |
| out_byte | output | DW (8) | Emitted byte, valid with out_valid |

## Verification
The bound checker watches several properties on every cycle:
- out_valid never lasts two cycles.
- out_valid and a rising irq only ever follow a control write.
- A status read always leaves irq low.
- Control readback always has bits 7 and 6 set.
- Unimplemented offsets read 0xFF.

Some behaviour only the bench scenarios can show, because it depends on history. These are the exact status values through the acknowledge walk, that the same-write interrupt enable does not count, the precedence of initialize over select, the byte carried by each pulse, the missing pulse on a repeated strobe, and the direction-dependent data readback.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int BYTE_W = 8;

    // Register offsets.
    localparam int OFS_DATA = 0;
    localparam int OFS_STAT = 1;
    localparam int OFS_CTRL = 2;

    // Control field positions.
    localparam int CB_STB = 0;
    localparam int CB_ALF = 1;
    localparam int CB_INI = 2;
    localparam int CB_SEL = 3;
    localparam int CB_IEN = 4;
    localparam int CB_DIR = 5;

    // Status field positions.
    localparam int SB_TMO = 0;
    localparam int SB_NERR = 3;
    localparam int SB_ONL = 4;
    localparam int SB_PAP = 5;
    localparam int SB_ACK = 6;
    localparam int SB_NBSY = 7;

    // Bits that every control write forces high.
    localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
    // Control value after reset: forced bits plus select and initialize.
    localparam logic [BYTE_W-1:0] CTRL_RST = CTRL_FORCE | (8'h1 << CB_SEL) | (8'h1 << CB_INI);
    // Value returned by an unimplemented offset.
    localparam logic [BYTE_W-1:0] FILL = 8'hFF;

    typedef enum logic [1:0] {
        HS_READY   = 2'd0,
        HS_STROBED = 2'd1,
        HS_ACK_LOW = 2'd2
    } hs_state_t;
endpackage

// File: rtl/lpt_hs_fsm.sv
module lpt_hs_fsm
    import lpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_reinit,
    input  logic ev_strobe,
    input  logic ev_stat_rd,
    output logic busy_n,
    output logic ack
);
    hs_state_t st_q;
    hs_state_t st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= HS_READY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (ev_reinit) begin
            st_d = HS_READY;                                  // T_REINIT
        end else begin
            unique case (st_q)
                HS_READY: begin
                    if (ev_strobe) st_d = HS_STROBED;         // T_STROBE
                end
                HS_STROBED: begin
                    if (ev_stat_rd) st_d = HS_ACK_LOW;        // T_ACK_DROP
                end
                HS_ACK_LOW: begin
                    if (ev_stat_rd) st_d = HS_READY;          // T_ACK_RISE
                end
                default: st_d = HS_READY;
            endcase
        end
    end

    always_comb begin
        unique case (st_q)
            HS_READY:   begin busy_n = 1'b1; ack = 1'b1; end
            HS_STROBED: begin busy_n = 1'b0; ack = 1'b1; end
            HS_ACK_LOW: begin busy_n = 1'b0; ack = 1'b0; end
            default:    begin busy_n = 1'b1; ack = 1'b1; end
        endcase
    end
endmodule

// File: rtl/lpt_ctl_regs.sv
module lpt_ctl_regs
    import lpt_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_data,
    input  logic          wr_ctrl,
    input  logic          stat_rd,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] data_q,
    output logic [DW-1:0] ctrl_q,
    output logic          pend_q,
    output logic          tmo_q,
    output logic          emit_valid,
    output logic [DW-1:0] emit_byte,
    output logic          ev_reinit,
    output logic          ev_strobe,
    output logic          ev_stat_rd
);
    localparam logic [DW-1:0] FORCE = DW'(CTRL_FORCE);
    localparam logic [DW-1:0] CRST  = DW'(CTRL_RST);

    logic ev_sel;
    logic ev_ring;
    logic ev_emit;

    always_comb begin
        ev_reinit  = wr_ctrl & ~wdata[CB_INI];
        ev_sel     = wr_ctrl &  wdata[CB_INI] & wdata[CB_SEL];
        ev_strobe  = ev_sel  &  wdata[CB_STB];
        ev_emit    = ev_strobe & ~ctrl_q[CB_STB];
        ev_ring    = ev_sel  & ~wdata[CB_STB] & ctrl_q[CB_IEN];
        ev_stat_rd = stat_rd & ~ctrl_q[CB_STB];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q     <= '1;
            ctrl_q     <= CRST;
            pend_q     <= 1'b0;
            tmo_q      <= 1'b1;
            emit_valid <= 1'b0;
            emit_byte  <= '0;
        end else begin
            emit_valid <= ev_emit;
            if (ev_emit)   emit_byte <= data_q;
            if (wr_data)   data_q <= wdata;
            if (wr_ctrl)   ctrl_q <= wdata | FORCE;
            if (ev_reinit) tmo_q <= 1'b0;
            if (ev_ring)       pend_q <= 1'b1;
            else if (stat_rd)  pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/lpt_rd_mux.sv
module lpt_rd_mux
    import lpt_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int AW = 3
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data_q,
    input  logic [DW-1:0] in_q,
    input  logic [DW-1:0] ctrl_q,
    input  logic [DW-1:0] stat_v,
    output logic [DW-1:0] value
);
    always_comb begin
        case (addr)
            AW'(OFS_DATA): value = ctrl_q[CB_DIR] ? in_q : data_q;
            AW'(OFS_STAT): value = stat_v;
            AW'(OFS_CTRL): value = ctrl_q;
            default:       value = DW'(FILL) | '1;
        endcase
    end
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
    import lpt_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] prn_din,
    output logic          irq,
    output logic          out_valid,
    output logic [DW-1:0] out_byte
);
    logic          rd_go;
    logic          wr_data;
    logic          wr_ctrl;
    logic          stat_rd;
    logic [DW-1:0] data_q;
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] in_q;
    logic [DW-1:0] stat_v;
    logic [DW-1:0] rd_val;
    logic          pend_q;
    logic          tmo_q;
    logic          ev_reinit;
    logic          ev_strobe;
    logic          ev_stat_rd;
    logic          busy_n;
    logic          ack;

    // A write wins over a read in the same cycle.
    always_comb begin
        rd_go   = bus_rd & ~bus_wr;
        wr_data = bus_wr & (bus_addr == AW'(OFS_DATA));
        wr_ctrl = bus_wr & (bus_addr == AW'(OFS_CTRL));
        stat_rd = rd_go  & (bus_addr == AW'(OFS_STAT));
    end

    lpt_ctl_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data    (wr_data),
        .wr_ctrl    (wr_ctrl),
        .stat_rd    (stat_rd),
        .wdata      (bus_wdata),
        .data_q     (data_q),
        .ctrl_q     (ctrl_q),
        .pend_q     (pend_q),
        .tmo_q      (tmo_q),
        .emit_valid (out_valid),
        .emit_byte  (out_byte),
        .ev_reinit  (ev_reinit),
        .ev_strobe  (ev_strobe),
        .ev_stat_rd (ev_stat_rd)
    );

    lpt_hs_fsm u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_reinit  (ev_reinit),
        .ev_strobe  (ev_strobe),
        .ev_stat_rd (ev_stat_rd),
        .busy_n     (busy_n),
        .ack        (ack)
    );

    always_comb begin
        stat_v          = '0;
        stat_v[SB_NBSY] = busy_n;
        stat_v[SB_ACK]  = ack;
        stat_v[SB_PAP]  = 1'b0;
        stat_v[SB_ONL]  = 1'b1;
        stat_v[SB_NERR] = 1'b1;
        stat_v[SB_TMO]  = tmo_q;
    end

    lpt_rd_mux #(.DW(DW), .AW(AW)) u_mux (
        .addr   (bus_addr),
        .data_q (data_q),
        .in_q   (in_q),
        .ctrl_q (ctrl_q),
        .stat_v (stat_v),
        .value  (rd_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q      <= '1;
            bus_rdata <= '1;
        end else begin
            in_q <= prn_din;
            if (rd_go) bus_rdata <= rd_val;
        end
    end

    assign irq = pend_q;
endmodule

// File: rtl/lpt_regs_chk.sv
module lpt_regs_chk #(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [DW-1:0] bus_rdata,
    input logic          irq,
    input logic          out_valid
);
    logic ctl_wr;
    logic sts_rd;
    logic ctl_rd;
    logic gap_rd;

    assign ctl_wr = bus_wr & (bus_addr == AW'(2));
    assign sts_rd = bus_rd & ~bus_wr & (bus_addr == AW'(1));
    assign ctl_rd = bus_rd & ~bus_wr & (bus_addr == AW'(2));
    assign gap_rd = bus_rd & ~bus_wr & (bus_addr > AW'(2));

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_pulse_after_ctl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(ctl_wr));

    assert_irq_after_ctl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ctl_wr));

    assert_stat_rd_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rd |=> !irq);

    assert_ctrl_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd |=> (bus_rdata[7:6] == 2'b11));

    assert_gap_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gap_rd |=> (bus_rdata == {DW{1'b1}}));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd & ~bus_wr) |=> $stable(bus_rdata));
endmodule

bind lpt_regs lpt_regs_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .out_valid (out_valid)
);

// File: tb/sim_lpt_regs.sv
module sim_lpt_regs;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] prn_din = 8'h00;
    logic       irq;
    logic       out_valid;
    logic [7:0] out_byte;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    logic rd_q = 1'b0;

    logic [7:0] rd_exp[$];
    string      rd_tag[$];
    logic [7:0] ob_exp[$];

    lpt_regs u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .prn_din   (prn_din),
        .irq       (irq),
        .out_valid (out_valid),
        .out_byte  (out_byte)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) rd_q <= bus_rd & ~bus_wr & rst_n;

    // Monitor: compare each read result and each emitted byte.
    always @(negedge clk) begin
        if (rd_q) begin
            logic [7:0] e;
            string t;
            e = rd_exp.pop_front();
            t = rd_tag.pop_front();
            nchk++;
            if (bus_rdata !== e) begin
                nerr++;
                $display("FAIL %s: rdata actual=%02h expected=%02h", t, bus_rdata, e);
            end
        end
        if (rst_n && out_valid) begin
            nchk++;
            if (ob_exp.size() == 0) begin
                nerr++;
                $display("FAIL R5: unexpected byte out actual=%02h expected=none", out_byte);
            end else begin
                logic [7:0] b;
                b = ob_exp.pop_front();
                if (out_byte !== b) begin
                    nerr++;
                    $display("FAIL R5: out_byte actual=%02h expected=%02h", out_byte, b);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        rd_exp.push_back(e);
        rd_tag.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%02h expected=%02h", t, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({7'd0, irq}, 8'h00, "R1 irq after reset");
        chk({7'd0, out_valid}, 8'h00, "R1 out_valid after reset");
        rd(3'd0, 8'hFF, "R1 data reset");
        rd(3'd1, 8'hD9, "R1 status reset");
        rd(3'd2, 8'hCC, "R1 control reset");

        for (int i = 3; i < 8; i++) rd(3'(i), 8'hFF, "R2 unimplemented offset");
        wr(3'd5, 8'h00);
        wr(3'd1, 8'h00);
        rd(3'd2, 8'hCC, "R2 control after gap write");
        rd(3'd1, 8'hD9, "R2 status after status write");

        wr(3'd0, 8'hA5);
        rd(3'd0, 8'hA5, "R9 data readback output mode");
        wr(3'd2, 8'h05);
        rd(3'd2, 8'hC5, "R3 forced bits 7:6");
        rd(3'd1, 8'hD9, "R3 no select no handshake");
        wr(3'd2, 8'h04);

        // Strobe edge with select: busy clears and A5 is emitted.
        ob_exp.push_back(8'hA5);
        wr(3'd2, 8'h0D);
        rd(3'd1, 8'h59, "R5 busy cleared");
        rd(3'd1, 8'h59, "R8 no step while strobe stored 1");
        wr(3'd2, 8'h0D);
        chk(8'(ob_exp.size()), 8'h00, "R5 pulse consumed");
        wr(3'd2, 8'h0C);
        chk({7'd0, irq}, 8'h00, "R6 no irq with enable off");

        rd(3'd1, 8'h59, "R8 read before ack drop");
        rd(3'd1, 8'h19, "R8 ack dropped");
        rd(3'd1, 8'hD9, "R8 ack and busy set");
        rd(3'd1, 8'hD9, "R8 ready holds");

        wr(3'd2, 8'h1C);
        chk({7'd0, irq}, 8'h00, "R6 same-write enable ignored");
        wr(3'd2, 8'h1C);
        chk({7'd0, irq}, 8'h01, "R6 irq raised");
        rd(3'd1, 8'hD9, "R7 status read with irq");
        chk({7'd0, irq}, 8'h00, "R7 irq cleared by status read");

        wr(3'd0, 8'h3C);
        ob_exp.push_back(8'h3C);
        wr(3'd2, 8'h1D);
        rd(3'd1, 8'h59, "R5 second strobe busy clear");
        wr(3'd2, 8'h18);
        chk({7'd0, irq}, 8'h00, "R4 init write raises no irq");
        rd(3'd1, 8'hD8, "R4 reinit status");
        rd(3'd2, 8'hD8, "R3 control after reinit");

        prn_din = 8'h5A;
        wr(3'd2, 8'h2C);
        rd(3'd0, 8'h5A, "R9 input latch");
        prn_din = 8'h81;
        @(negedge clk);
        rd(3'd0, 8'h81, "R9 input latch follows pins");
        wr(3'd2, 8'h0C);
        rd(3'd0, 8'h3C, "R9 back to written byte");

        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 8'h77; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk(bus_rdata, 8'h3C, "R10 read ignored on collision");
        @(negedge clk);
        chk(bus_rdata, 8'h3C, "R10 rdata holds");
        rd(3'd0, 8'h77, "R10 write performed on collision");

        repeat (3) @(negedge clk);
        chk(8'(ob_exp.size()), 8'h00, "R5 all bytes emitted");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule